// File: doc/BRIEF.md
# Address-Carried Configuration Byte Loader

This block keeps a 64-bit operating configuration that the rest of a memory controller reads continuously. Software changes it one byte at a time. The byte value travels in the address of a write cycle, not on the data bus. The block watches each address-strobed write cycle and decodes the address into four parts: a fixed window tag, a device number, a byte index and the byte value.

A write is accepted only when all of these hold:
- the tag matches the fixed window;
- the device number equals the board's 3-bit identity straps;
- the two lowest address bits are zero;
- the processor reports supervisor privilege.

An accepted write replaces exactly one byte of the stored vector on that clock edge. Every other cycle leaves the vector as it was. Several such blocks can share one bus, each with different strap values. The meaning of the individual configuration bits is decoded elsewhere.

Top module: `cfg_addr_loader`

## Requirements
- R1: While `rst_n` is low, every bit of `cfg` is driven to zero on each clock edge.
- R2: A write is accepted on a rising clock edge when `addr_stb`, `wr` and `sup` are all 1, `addr[31:16]` equals 16'hFF0F, `addr[15:13]` equals `dev_id`, and `addr[1:0]` is 2'b00.
- R3: An accepted write makes `cfg[8*k+7:8*k]` equal `addr[9:2]` from the next cycle on, where k is the value of `addr[12:10]`. Byte 0 is `cfg[7:0]` and byte 7 is `cfg[63:56]`.
- R4: An accepted write leaves the other seven bytes of `cfg` unchanged.
- R5: A cycle with `sup` at 0 leaves `cfg` unchanged, even when every address field matches.
- R6: A cycle whose `addr[15:13]` differs from `dev_id` leaves `cfg` unchanged.
- R7: A cycle whose `addr[31:16]` differs from 16'hFF0F leaves `cfg` unchanged.
- R8: A cycle with `addr[1:0]` not equal to 2'b00 leaves `cfg` unchanged.
- R9: A cycle with `addr_stb` at 0 or `wr` at 0 leaves `cfg` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_stb | input | 1 | Address valid strobe |
| wr | input | 1 | Cycle is a write |
| sup | input | 1 | Processor is in supervisor mode |
| addr | input | 32 | Address bus; carries the window tag, device number, byte index and byte value |
| dev_id | input | 3 | Identity straps of this device |
| cfg | output | 64 | Stored configuration vector |

## Verification
The bench runs every byte index against every strap value. Each accepted write must land in the indexed byte alone. A design that swaps the index order, or that spills into a neighbouring byte, shows up as a mismatch on the full 64-bit vector.

Each qualifier is then broken on its own while all the other fields still match:
- privilege;
- every wrong device number;
- each single flipped bit of the window tag;
- each nonzero pattern of the two low bits;
- strobe low and write low.

A design that ignores any one of these gates commits the offending byte, and the vector no longer matches the bench's model.

// File: rtl/cfg_addr_loader.sv
module cfg_addr_loader #(
  parameter int          AW        = 32,
  parameter int          ID_W      = 3,
  parameter int          NBYTES    = 8,
  parameter logic [15:0] BASE_TAG  = 16'hFF0F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_stb,
  input  logic                 wr,
  input  logic                 sup,
  input  logic [AW-1:0]        addr,
  input  logic [ID_W-1:0]      dev_id,
  output logic [NBYTES*8-1:0]  cfg
);
  localparam int CW    = NBYTES * 8;
  localparam int SEL_W = $clog2(NBYTES);
  localparam int DAT_LO = 2;
  localparam int SEL_LO = DAT_LO + 8;
  localparam int ID_LO  = SEL_LO + SEL_W;
  localparam int TAG_LO = ID_LO + ID_W;

  logic [SEL_W-1:0] sel;
  logic [7:0]       bval;
  logic             tag_ok, id_ok, low_ok, take;

  assign sel    = addr[SEL_LO +: SEL_W];
  assign bval   = addr[DAT_LO +: 8];
  assign tag_ok = addr[AW-1:TAG_LO] == BASE_TAG[AW-1-TAG_LO:0];
  assign id_ok  = addr[ID_LO +: ID_W] == dev_id;
  assign low_ok = addr[1:0] == 2'b00;
  assign take   = addr_stb & wr & sup & tag_ok & id_ok & low_ok;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg[8*k +: 8] <= 8'h00;
      else if (take && sel == SEL_W'(k))
        cfg[8*k +: 8] <= bval;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> cfg == '0);

  // R3
  byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cfg[$past(sel)*8 +: 8] == $past(bval));

  // R4
  others_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((cfg ^ $past(cfg)) & ~({{(CW-8){1'b0}}, 8'hFF} << ($past(sel)*8))) == '0);

  // R5
  user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup |=> $stable(cfg));

  // R6
  id_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[15:13] != dev_id) |=> $stable(cfg));

  // R7
  tag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[31:16] != 16'hFF0F) |=> $stable(cfg));

  // R8
  low_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00) |=> $stable(cfg));

  // R9
  idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_stb && wr) |=> $stable(cfg));
endmodule

// File: tb/cfg_addr_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_addr_loader_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        addr_stb = 0, wr = 0, sup = 0;
  logic [31:0] addr = '0;
  logic [2:0]  dev_id = '0;
  logic [63:0] cfg;
  logic [63:0] model = '0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cfg_addr_loader dut_i (.clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .wr(wr),
    .sup(sup), .addr(addr), .dev_id(dev_id), .cfg(cfg));

  function automatic logic [31:0] mk(input logic [15:0] tag, input logic [2:0] id,
                                     input logic [2:0] bsel, input logic [7:0] v,
                                     input logic [1:0] lo);
    return {tag, id, bsel, v, lo};
  endfunction

  task automatic check(input string req);
    total++;
    if (cfg !== model) begin
      bad++;
      $display("FAIL %s: cfg=%h expected=%h", req, cfg, model);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic p,
                     input logic [31:0] a, input logic [2:0] id, input string req);
    @(negedge clk);
    addr_stb = s; wr = w; sup = p; addr = a; dev_id = id;
    if (s && w && p && a[31:16] == 16'hFF0F && a[15:13] == id && a[1:0] == 2'b00)
      model[a[12:10]*8 +: 8] = a[9:2];
    @(negedge clk);
    addr_stb = 0; wr = 0;
    check(req);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: cycles exhausted, expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset clears, even with a matching write pending
    @(negedge clk);
    addr_stb = 1; wr = 1; sup = 1; addr = mk(16'hFF0F, 3'd0, 3'd2, 8'h5A, 2'b00);
    @(negedge clk); @(negedge clk);
    model = '0; check("R1");
    addr_stb = 0; wr = 0;
    rst_n = 1;

    // R2 R3 R4: sweep every id and byte index
    for (int id = 0; id < 8; id++)
      for (int b = 0; b < 8; b++)
        cyc(1, 1, 1, mk(16'hFF0F, 3'(id), 3'(b), 8'((id * 37 + b * 11 + 1) ^ 8'hA5), 2'b00), 3'(id), "R3/R4");

    // R3: extreme values in each byte
    for (int b = 0; b < 8; b++) begin
      cyc(1, 1, 1, mk(16'hFF0F, 3'd5, 3'(b), 8'hFF, 2'b00), 3'd5, "R3");
      cyc(1, 1, 1, mk(16'hFF0F, 3'd5, 3'(b), 8'h00, 2'b00), 3'd5, "R3");
      cyc(1, 1, 1, mk(16'hFF0F, 3'd5, 3'(b), 8'(8'h81 + b), 2'b00), 3'd5, "R2");
    end

    // R5: no privilege
    for (int b = 0; b < 8; b++)
      cyc(1, 1, 0, mk(16'hFF0F, 3'd2, 3'(b), 8'h3C, 2'b00), 3'd2, "R5");

    // R6: every wrong device number
    for (int id = 0; id < 8; id++)
      for (int f = 0; f < 8; f++)
        if (f != id)
          cyc(1, 1, 1, mk(16'hFF0F, 3'(f), 3'(f), 8'hC3, 2'b00), 3'(id), "R6");

    // R7: each single tag bit flipped
    for (int t = 0; t < 16; t++)
      cyc(1, 1, 1, mk(16'hFF0F ^ (16'h1 << t), 3'd1, 3'(t % 8), 8'h96, 2'b00), 3'd1, "R7");

    // R8: reserved low bits nonzero
    for (int l = 1; l < 4; l++)
      for (int b = 0; b < 8; b++)
        cyc(1, 1, 1, mk(16'hFF0F, 3'd3, 3'(b), 8'h69, 2'(l)), 3'd3, "R8");

    // R9: strobe or write missing
    for (int b = 0; b < 8; b++) begin
      cyc(0, 1, 1, mk(16'hFF0F, 3'd4, 3'(b), 8'h1E, 2'b00), 3'd4, "R9");
      cyc(1, 0, 1, mk(16'hFF0F, 3'd4, 3'(b), 8'hE1, 2'b00), 3'd4, "R9");
    end

    // R2: accepted write still works after the rejects
    cyc(1, 1, 1, mk(16'hFF0F, 3'd7, 3'd7, 8'h42, 2'b00), 3'd7, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule